// File: doc/BRIEF.md
# Page-Mode Parallel Flash Read Controller

This block sits on the host side of an asynchronous parallel NOR flash that offers page-mode reads. A client hands it read requests over a valid/ready handshake. The controller puts the address on the flash pins and pulls chip enable and output enable low. It waits a fixed number of clock cycles and then captures the data bus. The captured value goes back to the client on a one-cycle response strobe.

The wait depends on what the flash has just seen. A page is eight 16-bit words. The page is selected by word-address bits from the top down to bit 3, and bits 2..0 pick the word inside it. If chip enable has stayed low since the last access and the new word lies in the same page, the short page wait is enough. A move to another page while chip enable is held costs the full random-access wait. An access that opens a new chip-enable session must cover both the random-access time and the output-enable delay.

After a programmable run of idle cycles the controller raises chip enable, which closes the page. The next read is then treated as a fresh random access.

The bus can run 16 bits wide (word mode) or 8 bits wide (byte mode). In byte mode, data line 15 becomes an output that carries the lowest byte-address bit. Lines 14..8 are left undriven.

Top module: `pfr_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, chip enable, output enable and write enable are high, `req_ready` is high, `rsp_valid` is low and no data line is driven.
- R2: Write enable is high on every cycle.
- R3: When a request is accepted while chip enable is high, chip enable and output enable fall together with the new address. The bus is sampled `max(T_RAND, T_OE)` cycles after the accepting edge, and `rsp_valid` is high on the cycle that follows that sample edge.
- R4: If a request lies in the same eight-word page as the previous access and chip enable has stayed low since then, the bus is sampled `T_PAGE` cycles after acceptance.
- R5: If a request lies in a different page while chip enable is still low, chip enable stays low and the bus is sampled `T_RAND` cycles after acceptance.
- R6: After `IDLE_CLOSE` consecutive idle cycles following a response, chip enable and output enable go high. The next request, even one to the previously open page, is timed as in R3.
- R7: In word mode (`byte_mode` = 0), `req_addr[ADDR_W-1:0]` is the word address. It appears unchanged on `flash_addr`, no data line is driven, and `rsp_data` returns all 16 sampled bits.
- R8: In byte mode (`byte_mode` = 1), `req_addr[ADDR_W:1]` is the word address and `req_addr[0]` selects the byte. That byte-select bit is driven on data line 15, and `flash_dq_oe` equals 16'h8000. `rsp_data` is the sampled lines 7..0 zero-extended to 16 bits. All sixteen bytes of a page share the page timing of R4.
- R9: Each accepted request yields exactly one single-cycle response, in request order. `req_ready` is low while a read is in flight.
- R10: While a read is in flight, `flash_addr` and data line 15 do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_mode_i | input | 1 | 1 selects the 8-bit bus; change only while chip enable is high |
| req_valid_i | input | 1 | Read request present |
| req_ready_o | output | 1 | Controller can accept a request |
| req_addr_i | input | ADDR_W+1 | Word address (word mode) or byte address (byte mode) |
| rsp_valid_o | output | 1 | Read data valid for one cycle |
| rsp_data_o | output | 16 | Read word, or zero-extended byte |
| flash_ce_n_o | output | 1 | Flash chip enable, active low |
| flash_oe_n_o | output | 1 | Flash output enable, active low |
| flash_we_n_o | output | 1 | Flash write enable, held high |
| flash_addr_o | output | ADDR_W | Flash word address |
| flash_dq_i | input | 16 | Data bus as seen by the controller |
| flash_dq_o | output | 16 | Values driven onto the data bus |
| flash_dq_oe_o | output | 16 | Per-line drive enable for the data bus |

## Verification
The assertions watch properties that hold on every cycle:
- the address and byte-select line stay frozen during a pending access;
- chip enable stays low throughout a wait;
- responses never come on two cycles in a row;
- a timer is loaded only when it is idle;
- chip enable is dropped only when the idle count has run out.

The choice between page, random and session-opening waits, the data returned in each bus width, and the exact moment the page closes can only be shown by the bench's scenarios. Its flash model returns corrupt data whenever the bus is sampled too early.

// File: rtl/pfr_pkg.sv
`timescale 1ns/1ps
// Package: shared types and helpers for the page-mode flash read controller.
// Assumes nothing beyond IEEE 1800-2017 constant-function support.
package pfr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } pfr_state_e;

    // Larger of two cycle counts, used to size the session-opening wait.
    function automatic int unsigned pfr_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pfr_page_track.sv
`timescale 1ns/1ps
// Module: pfr_page_track
// Keeps the chip-enable session state and the number of the open page.
// It reports whether a candidate page hits the open one, and it closes the
// session after IDLE_CLOSE consecutive idle ticks.
// Assumes open_i and idle_i are never high together.
module pfr_page_track #(
    parameter int unsigned PAGE_W     = 21,
    parameter int unsigned IDLE_CLOSE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_i,
    input  logic              idle_i,
    input  logic [PAGE_W-1:0] page_i,
    output logic              sess_open_o,
    output logic              hit_o
);
    localparam int unsigned IDLE_W = $clog2(IDLE_CLOSE + 1);

    logic              open_q;
    logic [PAGE_W-1:0] page_q;
    logic [IDLE_W-1:0] idle_cnt_q;

    // Track the session and page; end the session when the idle budget is spent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q     <= 1'b0;
            page_q     <= '0;
            idle_cnt_q <= '0;
        end else if (open_i) begin
            open_q     <= 1'b1;
            page_q     <= page_i;
            idle_cnt_q <= '0;
        end else if (open_q && idle_i) begin
            if (idle_cnt_q == IDLE_W'(IDLE_CLOSE - 1)) begin
                open_q     <= 1'b0;
                idle_cnt_q <= '0;
            end else begin
                idle_cnt_q <= idle_cnt_q + 1'b1;
            end
        end else begin
            idle_cnt_q <= '0;
        end
    end

    // A hit needs both a live session and a matching page number.
    always_comb begin
        sess_open_o = open_q;
        hit_o       = open_q && (page_q == page_i);
    end

    // R6: the session ends only when the idle count has just run out.
    p_close_on_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(open_q) |-> ($past(idle_cnt_q) == IDLE_W'(IDLE_CLOSE - 1)));

endmodule

// File: rtl/pfr_wait_timer.sv
`timescale 1ns/1ps
// Module: pfr_wait_timer
// Down-counter that times the gap from an address change to the bus sample.
// done_o is high during the cycle whose closing edge is the sample edge.
// Assumes load_val_i is at least 1.
module pfr_wait_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load on a new access, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Last cycle of the wait.
    always_comb done_o = (cnt_q == CNT_W'(1));

    // R9: a new access is never started while a wait is still running.
    p_load_when_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (cnt_q == '0));

endmodule

// File: rtl/pfr_ctrl.sv
`timescale 1ns/1ps
// Module: pfr_ctrl (top)
// Host-side read controller for an asynchronous page-mode NOR flash.
// It accepts one read at a time, chooses the page, random or
// session-opening wait, captures the bus and returns the data in order.
// Assumes byte_mode_i changes only while chip enable is high and that
// every timing parameter is at least 1.
module pfr_ctrl #(
    parameter int unsigned ADDR_W     = 24,
    parameter int unsigned T_RAND     = 9,
    parameter int unsigned T_PAGE     = 3,
    parameter int unsigned T_OE       = 4,
    parameter int unsigned IDLE_CLOSE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W:0]   req_addr_i,
    output logic              rsp_valid_o,
    output logic [15:0]       rsp_data_o,
    output logic              flash_ce_n_o,
    output logic              flash_oe_n_o,
    output logic              flash_we_n_o,
    output logic [ADDR_W-1:0] flash_addr_o,
    input  logic [15:0]       flash_dq_i,
    output logic [15:0]       flash_dq_o,
    output logic [15:0]       flash_dq_oe_o
);
    import pfr_pkg::*;

    localparam int unsigned PAGE_W  = ADDR_W - 3;
    localparam int unsigned T_FIRST = pfr_max(T_RAND, T_OE);
    localparam int unsigned CNT_W   = $clog2(T_FIRST + 1);
    localparam logic [CNT_W-1:0] W_FIRST = CNT_W'(T_FIRST);
    localparam logic [CNT_W-1:0] W_RAND  = CNT_W'(T_RAND);
    localparam logic [CNT_W-1:0] W_PAGE  = CNT_W'(T_PAGE);

    pfr_state_e        state_q;
    logic [ADDR_W-1:0] word_addr, addr_q;
    logic              lsb_sel, lsb_q, mode_q;
    logic              accept, idle_tick, sess_open, page_hit, wait_done;
    logic [CNT_W-1:0]  wait_val;
    logic              rsp_valid_q;
    logic [15:0]       rsp_data_q;

    // Split the request address by bus width and classify the request.
    always_comb begin
        word_addr = byte_mode_i ? req_addr_i[ADDR_W:1] : req_addr_i[ADDR_W-1:0];
        lsb_sel   = byte_mode_i & req_addr_i[0];
        accept    = req_valid_i && (state_q == ST_IDLE);
        idle_tick = (state_q == ST_IDLE) && !req_valid_i;
        if (!sess_open)   wait_val = W_FIRST;
        else if (page_hit) wait_val = W_PAGE;
        else               wait_val = W_RAND;
    end

    pfr_page_track #(
        .PAGE_W     (PAGE_W),
        .IDLE_CLOSE (IDLE_CLOSE)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_i      (accept),
        .idle_i      (idle_tick),
        .page_i      (word_addr[ADDR_W-1:3]),
        .sess_open_o (sess_open),
        .hit_o       (page_hit)
    );

    pfr_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i (wait_val),
        .done_o     (wait_done)
    );

    // Access sequencing: latch the address on accept, capture data at the end of the wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            addr_q      <= '0;
            lsb_q       <= 1'b0;
            mode_q      <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (accept) begin
                state_q <= ST_WAIT;
                addr_q  <= word_addr;
                lsb_q   <= lsb_sel;
                mode_q  <= byte_mode_i;
            end else if ((state_q == ST_WAIT) && wait_done) begin
                state_q     <= ST_IDLE;
                rsp_valid_q <= 1'b1;
                rsp_data_q  <= mode_q ? {8'h00, flash_dq_i[7:0]} : flash_dq_i;
            end
        end
    end

    // Pin drive: strobes follow the session, and line 15 carries the byte select in byte mode.
    always_comb begin
        req_ready_o   = (state_q == ST_IDLE);
        rsp_valid_o   = rsp_valid_q;
        rsp_data_o    = rsp_data_q;
        flash_ce_n_o  = ~sess_open;
        flash_oe_n_o  = ~sess_open;
        flash_we_n_o  = 1'b1;
        flash_addr_o  = addr_q;
        flash_dq_o    = {lsb_q, 15'b0};
        flash_dq_oe_o = {byte_mode_i, 15'b0};
    end

    // R10: the address and the byte-select line hold still during a wait.
    p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT) && $past(state_q == ST_WAIT)) |->
            ($stable(flash_addr_o) && $stable(flash_dq_o)));

    // R5: chip enable stays low for the whole of a wait.
    p_ce_held_in_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> !flash_ce_n_o);

    // R9: a response lasts exactly one cycle.
    p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o);

endmodule

// File: tb/pfr_ctrl_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected data and latency, the
// monitor compares each response. A behavioural flash model corrupts the
// data whenever the bus is sampled before its timing is met.
module pfr_ctrl_tb_top;
    localparam int AW = 12;
    localparam int TR = 5;
    localparam int TP = 2;
    localparam int TO = 7;
    localparam int IC = 6;
    localparam int TF = (TR > TO) ? TR : TO;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          byte_mode;
    logic          req_valid;
    logic          req_ready;
    logic [AW:0]   req_addr;
    logic          rsp_valid;
    logic [15:0]   rsp_data;
    logic          ce_n, oe_n, we_n;
    logic [AW-1:0] faddr;
    logic [15:0]   dq_in, dq_out, dq_oe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        logic [15:0] data;
        int          lat;
        int          acc;
        string       req;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    pfr_ctrl #(
        .ADDR_W (AW), .T_RAND (TR), .T_PAGE (TP), .T_OE (TO), .IDLE_CLOSE (IC)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .byte_mode_i (byte_mode),
        .req_valid_i (req_valid), .req_ready_o (req_ready), .req_addr_i (req_addr),
        .rsp_valid_o (rsp_valid), .rsp_data_o (rsp_data),
        .flash_ce_n_o (ce_n), .flash_oe_n_o (oe_n), .flash_we_n_o (we_n),
        .flash_addr_o (faddr), .flash_dq_i (dq_in), .flash_dq_o (dq_out),
        .flash_dq_oe_o (dq_oe)
    );

    function automatic logic [15:0] fword(input logic [AW-1:0] a);
        logic [31:0] p;
        p = {20'h0, a} * 32'd40503;
        return p[15:0] ^ 16'h5A5A;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Flash model: ages the pins at each falling edge and drives valid data only when timing is met.
    logic [AW-1:0] m_addr = '0;
    logic m_ce = 1'b1, m_oe = 1'b1, m_lsb = 1'b0;
    int age = 0, oe_age = 0, need = TR;
    always @(negedge clk) begin
        logic lsb;
        logic [15:0] w, v;
        lsb = dq_oe[15] ? dq_out[15] : 1'b0;
        if (faddr != m_addr || ce_n != m_ce || lsb != m_lsb) begin
            need = (!m_ce && !ce_n && m_addr[AW-1:3] == faddr[AW-1:3]) ? TP : TR;
            age = 1;
        end else if (age < 1000) begin
            age++;
        end
        if (oe_n) oe_age = 0;
        else if (!m_oe) oe_age = (oe_age < 1000) ? oe_age + 1 : oe_age;
        else oe_age = 1;
        m_addr = faddr; m_ce = ce_n; m_oe = oe_n; m_lsb = lsb;
        w = fword(faddr);
        v = byte_mode ? {dq_out[15], 7'h55, (lsb ? w[15:8] : w[7:0])} : w;
        if (!ce_n && !oe_n && age >= need && oe_age >= TO) dq_in = v;
        else dq_in = ~v;
    end

    // Monitor: pops the scoreboard on every response; also watches write enable (R2).
    always @(negedge clk) begin
        if (rst_n) begin
            if (we_n !== 1'b1) check(1'b0, "R2", "write enable low", 32'(we_n), 32'd1);
            if (rsp_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R9", "response with no request", 32'(rsp_data), 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(rsp_data == e.data, e.req, "read data", 32'(rsp_data), 32'(e.data));
                    check(cyc - e.acc == e.lat, e.req, "sample latency",
                          32'(cyc - e.acc), 32'(e.lat));
                end
            end
        end
    end

    // Driver: issue one read and queue its expected data and latency.
    task automatic rd(input logic [AW:0] ra, input string req);
        exp_t e;
        logic [AW-1:0] wa;
        logic [15:0] w;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        wa = byte_mode ? ra[AW:1] : ra[AW-1:0];
        w  = fword(wa);
        e.data = byte_mode ? {8'h00, (ra[0] ? w[15:8] : w[7:0])} : w;
        e.lat  = ce_n ? TF : ((wa[AW-1:3] == faddr[AW-1:3]) ? TP : TR);
        e.acc  = cyc + 1;
        e.req  = req;
        req_addr  = ra;
        req_valid = 1'b1;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        check(faddr == wa, byte_mode ? "R8" : "R7", "flash address", 32'(faddr), 32'(wa));
        check(!ce_n && !oe_n, "R3", "strobes low in access", {30'h0, ce_n, oe_n}, 32'd0);
        check(!req_ready, "R9", "ready low while pending", 32'(req_ready), 32'd0);
        if (byte_mode)
            check(dq_oe == 16'h8000 && dq_out[15] == ra[0], "R8", "line 15 drive",
                  {dq_oe, dq_out}, {16'h8000, ra[0], 15'h0});
        else
            check(dq_oe == 16'h0000, "R7", "no data line driven", 32'(dq_oe), 32'd0);
    endtask

    // Wait for the pending response, then confirm the page closes after exactly IC idle cycles (R6).
    task automatic idle_close;
        while (!rsp_valid) @(negedge clk);
        for (int k = 1; k < IC; k++) @(negedge clk);
        check(!ce_n, "R6", "still open one cycle early", 32'(ce_n), 32'd0);
        @(negedge clk);
        check(ce_n && oe_n, "R6", "closed after idle run", {30'h0, ce_n, oe_n}, 32'd3);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; byte_mode = 1'b0; req_valid = 1'b0; req_addr = '0;
        repeat (3) @(negedge clk);
        check(ce_n && oe_n && we_n && req_ready && !rsp_valid && dq_oe == 16'h0,
              "R1", "reset state", {26'h0, ce_n, oe_n, we_n, req_ready, rsp_valid, |dq_oe},
              32'h3C);
        rst_n = 1'b1;
        @(negedge clk);
        check(ce_n && req_ready && !rsp_valid, "R1", "first cycle after reset",
              {29'h0, ce_n, req_ready, rsp_valid}, 32'h6);

        // Word mode: open, in-page hops, page switches.
        rd(13'h0120, "R3");
        rd(13'h0125, "R4");
        rd(13'h0127, "R4");
        rd(13'h0121, "R4");
        rd(13'h03A0, "R5");
        rd(13'h03A6, "R4");
        rd(13'h0120, "R5");
        idle_close();
        rd(13'h0121, "R6");
        rd(13'h0122, "R7");
        idle_close();

        // Byte mode, switched while chip enable is high.
        byte_mode = 1'b1;
        rd(13'h0A41, "R8");
        rd(13'h0A40, "R8");
        rd(13'h0A4F, "R8");
        rd(13'h1000, "R5");
        rd(13'h1001, "R8");
        idle_close();

        // Back-to-back in-page stream in word mode, checked in order (R9).
        byte_mode = 1'b0;
        for (int i = 0; i < 8; i++) rd(13'(13'h0458 + ((i * 3) % 8)), "R9");
        while (!rsp_valid) @(negedge clk);
        @(negedge clk);
        check(q.size() == 0, "R9", "all responses returned", 32'(q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule